// File: doc/BRIEF.md
# Reset Source and Wake-up Startup Controller

This block gathers every reason for resetting a small microcontroller core: the power-on condition, an external reset pin, a brown-out (low-voltage) detector and a watchdog expiry. It turns them into a held core stall, a full system reset, and a set of clear strobes for the program counter, stack pointer, interrupt enables, timer, prescaler, port directions and the watchdog. It also keeps the two status bits that software reads to learn why it restarted. One bit records a watchdog expiry (`to_flag`). The other records power-down (`pd_flag`). The block also tracks whether the core is running at normal speed, running slow, or asleep.

Each request loads a startup counter. The core stays stalled until that counter has run down, and a one-cycle `ready` pulse then marks the release. A watchdog expiry while the core sleeps does not reset the whole core. It clears only the program counter and stack pointer and keeps all other state. A plain wake-up event clears nothing and only waits out the oscillator settling time. That time is 128 cycles, or 2 cycles when an RC oscillator is used and the short option is selected.

Top module: `rstsrc_ctrl`

## Requirements
- R1: While `por_n` is low, `core_hold`, `sys_rst` and every full-reset strobe are 1 and both status flags are 0. After `por_n` rises, `core_hold` falls on the (RST_DLY+1)-th rising clock edge.
- R2: A reset from the external pin (`pin_rst_n` low) or from the voltage detector (`lvd_rst` high) first passes a two-flop synchronizer. It then starts a full reset and leaves `to_flag` and `pd_flag` unchanged. `core_hold` falls on the (RST_DLY+3)-th edge after the source is removed.
- R3: A watchdog expiry (`wdt_to` high at an edge) while the core is not asleep and not stalled starts a full reset on that edge. It sets `to_flag` to 1, keeps `pd_flag`, and `core_hold` falls on the (RST_DLY+2)-th edge counted from the sampling edge.
- R4: A watchdog expiry while asleep sets both flags to 1. It raises only `pc_clr` and `sp_clr`, with `sys_rst` and all other strobes at 0, and leaves sleep.
- R5: The wake-up delay D is 2 when `osc_xtal`=0 and `fast_wake`=1, and 128 in every other case. `core_hold` falls on the (D+2)-th edge counted from the edge that samples the wake or watchdog event.
- R6: A `sleep_req` strobe while running and not stalled sets `pd_flag` to 1, clears `to_flag` and moves `mode` to 2'b10 (sleep).
- R7: A `clrwdt` strobe while running and not stalled, with no `sleep_req` in the same cycle, clears both flags.
- R8: When several sources are active together, the voltage detector and the external pin win over the watchdog. A watchdog expiry seen while a synchronized pin or detector request is active leaves `to_flag` unchanged.
- R9: `ready` is high for exactly the one cycle following the edge on which `core_hold` falls.
- R10: While awake, `mode` is 2'b00 (normal) when `slow_en`=0 and 2'b01 (slow) when `slow_en`=1.
- R11: A `wake` strobe while asleep stalls the core for the wake-up delay with no clear strobe and no `sys_rst`, and returns `mode` to the running encoding.
- R12: `sleep_req` and `clrwdt` are ignored while `core_hold` is high. The mode and the flags after release are the ones the reset produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | External reset pin, asynchronous, active low |
| lvd_rst | input | 1 | Low-voltage detector request, asynchronous, active high |
| wdt_to | input | 1 | Watchdog expiry, synchronous |
| wake | input | 1 | Wake-up event strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| clrwdt | input | 1 | Clear-watchdog instruction strobe |
| slow_en | input | 1 | Selects slow running mode |
| fast_wake | input | 1 | Picks the short wake-up delay for RC clock sources |
| osc_xtal | input | 1 | 1 when the clock comes from a crystal |
| core_hold | output | 1 | Core stalled |
| sys_rst | output | 1 | Full synchronous system reset |
| ready | output | 1 | One-cycle pulse on release |
| pc_clr | output | 1 | Clear program counter |
| sp_clr | output | 1 | Reset stack pointer to top |
| int_dis | output | 1 | Disable all interrupts |
| tmr_off | output | 1 | Stop the timer |
| psc_clr | output | 1 | Clear the prescaler |
| io_in | output | 1 | Force ports to input |
| wdt_clr | output | 1 | Clear and restart the watchdog |
| to_flag | output | 1 | Watchdog expiry status |
| pd_flag | output | 1 | Power-down status |
| mode | output | 2 | 00 normal, 01 slow, 10 sleep |

## Verification
Strobes and the watchdog input take effect on the edge that samples them, so flags, mode and clear strobes are read half a cycle after that edge. The pin and detector requests first cross two synchronizer flops and appear only after the third edge. The release is checked by counting rising edges from the stimulus until `core_hold` falls. That count must equal RST_DLY+1 from power-on, RST_DLY+2 from a watchdog edge, RST_DLY+3 from removal of a pin or detector request, and D+2 from a wake or sleep-watchdog edge. `ready` is then checked high at that sample and low one cycle later. All sampling happens at falling edges, with inputs changed there too.

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl #(
  parameter int RST_DLY   = 16,
  parameter int SST_LONG  = 128,
  parameter int SST_SHORT = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       lvd_rst,
  input  logic       wdt_to,
  input  logic       wake,
  input  logic       sleep_req,
  input  logic       clrwdt,
  input  logic       slow_en,
  input  logic       fast_wake,
  input  logic       osc_xtal,
  output logic       core_hold,
  output logic       sys_rst,
  output logic       ready,
  output logic       pc_clr,
  output logic       sp_clr,
  output logic       int_dis,
  output logic       tmr_off,
  output logic       psc_clr,
  output logic       io_in,
  output logic       wdt_clr,
  output logic       to_flag,
  output logic       pd_flag,
  output logic [1:0] mode
);

  localparam int MAXD = (RST_DLY > SST_LONG) ? RST_DLY : SST_LONG;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [1:0] K_FULL = 2'd0, K_PART = 2'd1, K_WAKE = 2'd2;

  logic [1:0]    pin_q, lvd_q, kind;
  logic [CW-1:0] cnt;
  logic          sleeping;

  wire ext_req  = pin_q[1] | lvd_q[1];
  wire idle     = ~core_hold & ~ext_req;
  wire wdt_full = idle & wdt_to & ~sleeping;
  wire wdt_part = idle & wdt_to & sleeping;
  wire wake_ev  = idle & wake & sleeping & ~wdt_to;
  wire do_sleep = idle & sleep_req & ~sleeping & ~wdt_to;
  wire do_clr   = idle & clrwdt & ~sleep_req & ~sleeping & ~wdt_to;
  wire [CW-1:0] sst = (osc_xtal || !fast_wake) ? CW'(SST_LONG) : CW'(SST_SHORT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_q     <= '0;
      lvd_q     <= '0;
      cnt       <= CW'(RST_DLY);
      kind      <= K_FULL;
      core_hold <= 1'b1;
      ready     <= 1'b0;
      sleeping  <= 1'b0;
      to_flag   <= 1'b0;
      pd_flag   <= 1'b0;
    end else begin
      pin_q <= {pin_q[0], ~pin_rst_n};
      lvd_q <= {lvd_q[0], lvd_rst};
      ready <= 1'b0;
      if (ext_req || wdt_full) begin
        core_hold <= 1'b1;
        kind      <= K_FULL;
        cnt       <= CW'(RST_DLY);
        sleeping  <= 1'b0;
        if (wdt_full) to_flag <= 1'b1;
      end else if (wdt_part || wake_ev) begin
        core_hold <= 1'b1;
        kind      <= wdt_part ? K_PART : K_WAKE;
        cnt       <= sst;
        sleeping  <= 1'b0;
        if (wdt_part) begin
          to_flag <= 1'b1;
          pd_flag <= 1'b1;
        end
      end else if (core_hold) begin
        if (cnt != '0) cnt <= cnt - CW'(1);
        else begin
          core_hold <= 1'b0;
          ready     <= 1'b1;
        end
      end else if (do_sleep) begin
        sleeping <= 1'b1;
        pd_flag  <= 1'b1;
        to_flag  <= 1'b0;
      end else if (do_clr) begin
        to_flag <= 1'b0;
        pd_flag <= 1'b0;
      end
    end
  end

  wire full = core_hold & (kind == K_FULL);
  wire ptr  = core_hold & (kind != K_WAKE);

  assign sys_rst = full;
  assign int_dis = full;
  assign tmr_off = full;
  assign psc_clr = full;
  assign io_in   = full;
  assign wdt_clr = full;
  assign pc_clr  = ptr;
  assign sp_clr  = ptr;
  assign mode    = sleeping ? 2'b10 : {1'b0, slow_en};

endmodule

module rstsrc_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       ext_req,
  input logic       wdt_to,
  input logic       sleep_req,
  input logic       clrwdt,
  input logic       core_hold,
  input logic       sys_rst,
  input logic       ready,
  input logic       pc_clr,
  input logic       to_flag,
  input logic       pd_flag,
  input logic [1:0] mode
);

  p_ext_keeps_flags_r2: assert property (@(posedge clk) disable iff (!por_n)
    ext_req |=> core_hold && sys_rst && $stable(to_flag) && $stable(pd_flag));

  p_wdt_run_r3: assert property (@(posedge clk) disable iff (!por_n)
    wdt_to && !core_hold && !ext_req && mode != 2'b10 |=> to_flag && sys_rst && $stable(pd_flag));

  p_wdt_sleep_r4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_to && !core_hold && !ext_req && mode == 2'b10 |=> to_flag && pd_flag && pc_clr && !sys_rst);

  p_sleep_entry_r6: assert property (@(posedge clk) disable iff (!por_n)
    sleep_req && !core_hold && !ext_req && !wdt_to && mode != 2'b10 |=> pd_flag && !to_flag && mode == 2'b10);

  p_clr_flags_r7: assert property (@(posedge clk) disable iff (!por_n)
    clrwdt && !sleep_req && !core_hold && !ext_req && !wdt_to && mode != 2'b10 |=> !to_flag && !pd_flag);

  p_ready_edge_r9: assert property (@(posedge clk) disable iff (!por_n)
    ready |-> $past(core_hold) && !core_hold);

  p_no_sleep_in_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
    core_hold |=> mode != 2'b10);

endmodule

bind rstsrc_ctrl rstsrc_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .ext_req(ext_req), .wdt_to(wdt_to),
  .sleep_req(sleep_req), .clrwdt(clrwdt), .core_hold(core_hold),
  .sys_rst(sys_rst), .ready(ready), .pc_clr(pc_clr),
  .to_flag(to_flag), .pd_flag(pd_flag), .mode(mode)
);

// File: tb/test_rstsrc_ctrl.sv
`timescale 1ns/1ps
module test_rstsrc_ctrl;
  localparam int D = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, pin_rst_n = 1'b1, lvd_rst = 1'b0, wdt_to = 1'b0, wake = 1'b0;
  logic sleep_req = 1'b0, clrwdt = 1'b0, slow_en = 1'b0, fast_wake = 1'b0, osc_xtal = 1'b0;
  logic core_hold, sys_rst, ready, pc_clr, sp_clr, int_dis, tmr_off, psc_clr, io_in, wdt_clr;
  logic to_flag, pd_flag;
  logic [1:0] mode;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rstsrc_ctrl #(.RST_DLY(D), .SST_LONG(128), .SST_SHORT(2)) i_rstsrc_ctrl (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rel(int start, int exp, string tag);
    int n = start;
    while (core_hold && n < 400) begin step(); n++; end
    chk({tag, " release edge"}, n, exp);
    chk("R9 ready pulse high", ready, 1);
    step();
    chk("R9 ready pulse low", ready, 0);
  endtask

  task automatic full_strobes(string tag, int v);
    chk({tag, " sys_rst"}, sys_rst, v);
    chk({tag, " strobes"}, {pc_clr, sp_clr, int_dis, tmr_off, psc_clr, io_in, wdt_clr}, v ? 127 : 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    // R1 power-on state
    chk("R1 hold", core_hold, 1);
    full_strobes("R1", 1);
    chk("R1 flags", {to_flag, pd_flag}, 0);
    por_n = 1'b1;
    wait_rel(0, D + 1, "R1");

    // R10 running modes
    slow_en = 1'b1; #1;
    chk("R10 slow", mode, 1);
    slow_en = 1'b0; #1;
    chk("R10 normal", mode, 0);

    // R6 sleep entry
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R6 mode", mode, 2);
    chk("R6 flags", {to_flag, pd_flag}, 1);

    // R11 plain wake with short RC delay
    fast_wake = 1'b1; osc_xtal = 1'b0;
    wake = 1'b1; step(); wake = 1'b0;
    chk("R11 hold", core_hold, 1);
    chk("R11 no clears", {sys_rst, pc_clr, sp_clr, io_in}, 0);
    chk("R11 mode", mode, 0);
    wait_rel(1, 4, "R5 R11");

    // R4/R5 sweep of clock source and option with watchdog in sleep
    for (int c = 0; c < 4; c++) begin
      int dly;
      osc_xtal = c[1]; fast_wake = c[0];
      dly = (c[1] || !c[0]) ? 128 : 2;
      sleep_req = 1'b1; step(); sleep_req = 1'b0;
      chk("R6 sweep sleep", mode, 2);
      wdt_to = 1'b1; step(); wdt_to = 1'b0;
      chk("R4 flags", {to_flag, pd_flag}, 3);
      chk("R4 ptr clears", {pc_clr, sp_clr}, 3);
      chk("R4 other strobes", {sys_rst, int_dis, tmr_off, psc_clr, io_in, wdt_clr}, 0);
      chk("R4 mode", mode, 0);
      wait_rel(1, dly + 2, "R5");
    end

    // R2 pin reset keeps flags (both 1 now)
    pin_rst_n = 1'b0;
    step(); step();
    chk("R2 pin not yet", core_hold, 0);
    step();
    full_strobes("R2 pin", 1);
    repeat (3) step();
    pin_rst_n = 1'b1;
    wait_rel(0, D + 3, "R2 pin");
    chk("R2 pin flags", {to_flag, pd_flag}, 3);

    lvd_rst = 1'b1;
    repeat (3) step();
    full_strobes("R2 lvd", 1);
    lvd_rst = 1'b0;
    wait_rel(0, D + 3, "R2 lvd");
    chk("R2 lvd flags", {to_flag, pd_flag}, 3);

    // R7 clear-watchdog
    clrwdt = 1'b1; step(); clrwdt = 1'b0;
    chk("R7 flags", {to_flag, pd_flag}, 0);

    // R3 watchdog while running, R12 strobes ignored in hold
    wdt_to = 1'b1; step(); wdt_to = 1'b0;
    full_strobes("R3", 1);
    chk("R3 flags", {to_flag, pd_flag}, 2);
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    clrwdt = 1'b1; step(); clrwdt = 1'b0;
    wait_rel(3, D + 2, "R3");
    chk("R12 mode", mode, 0);
    chk("R12 flags", {to_flag, pd_flag}, 2);

    // R8 pin wins over watchdog
    clrwdt = 1'b1; step(); clrwdt = 1'b0;
    pin_rst_n = 1'b0;
    step(); step();
    wdt_to = 1'b1; step(); wdt_to = 1'b0;
    chk("R8 hold", sys_rst, 1);
    chk("R8 to unchanged", to_flag, 0);
    pin_rst_n = 1'b1;
    wait_rel(0, D + 3, "R8");
    chk("R8 flags after", {to_flag, pd_flag}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule